// File: doc/BRIEF.md
# SDRAM command decoder and bank tracker

This block is the device-side command front end of a four-bank synchronous DRAM. On every rising clock edge it samples the chip select, the three command strobes, the bank address, the address bus and the data mask. It decodes the command, checks it against the state of each bank, and either accepts it or rejects it. For every bank it keeps a small state machine (idle, open, bursting a read, bursting a write, precharging) and the row that was opened last.

Accepted reads and writes start a burst of fixed length. For each beat the block drives an internal read or write enable toward the array and names the bank of that beat. The data mask works in two ways. On a write it blocks the write enable in the same clock in which it is sampled. On a read it removes the output enable of the data bus two clocks after it is sampled. Address bit 10 has two meanings. On a read or write it asks for an automatic precharge once the burst is done. On a precharge it selects every bank, and the bank address is then ignored.

Any rejected command sets a sticky error flag and changes nothing. A strobe vector reports which command was accepted at the last edge.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: With `cs_n` high the command inputs are ignored. With `cs_n` low, `{ras_n,cas_n,we_n}` decodes as 111 no-op, 011 activate, 101 read, 100 write, 110 burst stop, 010 precharge, 001 refresh and 000 mode set. After each edge, `cmd_seen` holds one bit for the command accepted at that edge: bit0 activate, bit1 read, bit2 write, bit3 burst stop, bit4 precharge, bit5 refresh, bit6 mode set. It holds all zero when no command was accepted.
- R2: An activate to a ready bank opens it. After the edge, `bank_open[ba]` is 1 and `row_tbl[ba*ROW_W +: ROW_W]` holds the address. The bank index is the value of `ba`.
- R3: A read or write to an open bank issues BURST_LEN beats, one on each consecutive edge, starting at the command edge. `rd_en` or `wr_en` is high in the cycle before each beat edge, and `beat_bank` names the bank.
- R4: During a write beat, `dqm` high forces `wr_en` low in that same cycle. The other beats are not affected.
- R5: A read beat issued at edge k raises `dq_oe` for the cycle after edge k+2. If `dqm` was high at edge k, `dq_oe` stays low for that cycle instead.
- R6: A read or write with `addr[10]` high closes its bank at the edge of its last beat. An activate to that bank is rejected until T_RP edges later.
- R7: While a burst with automatic precharge is running, any read or write is rejected, and so is a precharge that reaches the bursting bank.
- R8: A precharge with `addr[10]` high closes every open bank and ignores `ba`. With `addr[10]` low it closes only bank `ba`. An activate to a closed bank is accepted from T_RP edges after the precharge edge onward.
- R9: A burst stop ends the running burst at any beat. No further beat enable follows it.
- R10: Mode set and refresh are accepted only when all four banks are ready. After an accepted mode set, any command other than a no-op in the next T_MRD-1 edges is rejected.
- R11: A rejected command sets `err`, which stays high until reset. A rejected command produces no strobe and leaves the row table and the bank states unchanged. Examples are a read to an idle bank and an activate to an open bank.
- R12: During reset and at its release, all banks are idle, and `err`, `cmd_seen`, `rd_en`, `wr_en` and `dq_oe` are low.
- R13: A read or write accepted while a burst without automatic precharge is running cuts that burst off. Its first beat is issued at the same edge, for its own bank and direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| ba | input | 2 | Bank index |
| addr | input | ROW_W | Row address on activate; bit 10 selects the precharge mode |
| dqm | input | 1 | Data mask |
| rd_en | output | 1 | A read beat is taken at the next edge |
| wr_en | output | 1 | An unmasked write beat is taken at the next edge |
| beat_bank | output | 2 | Bank of the current beat |
| dq_oe | output | 1 | Data bus output enable, with read mask applied |
| cmd_seen | output | 7 | One-hot strobe of the command accepted at the last edge |
| bank_open | output | 4 | Per-bank open-row indication |
| row_tbl | output | 4*ROW_W | Last activated row of each bank |
| err | output | 1 | Sticky illegal-command flag |

## Verification
The hardest state to reach from the ports is a burst that overlaps another command. This covers a read cut off by a write to a second bank, a read rejected during a burst with automatic precharge, and an activate that arrives one edge before the precharge time is over. The stimulus table drives these in one continuous sequence, so each case starts from the state the earlier rows left behind. Masked beats are placed in the middle of bursts, so the two mask latencies show up in different cycles.

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker #(
  parameter int ROW_W     = 12,
  parameter int BURST_LEN = 4,
  parameter int T_RP      = 2,
  parameter int T_MRD     = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_n,
  input  logic               ras_n,
  input  logic               cas_n,
  input  logic               we_n,
  input  logic [1:0]         ba,
  input  logic [ROW_W-1:0]   addr,
  input  logic               dqm,
  output logic               rd_en,
  output logic               wr_en,
  output logic [1:0]         beat_bank,
  output logic               dq_oe,
  output logic [6:0]         cmd_seen,
  output logic [3:0]         bank_open,
  output logic [4*ROW_W-1:0] row_tbl,
  output logic               err
);

  localparam int AP_BIT = 10;
  localparam int BCW    = $clog2(BURST_LEN + 1);
  localparam int PTW    = $clog2(T_RP + 1);
  localparam int MW     = $clog2(T_MRD + 1);

  typedef enum logic [2:0] {B_IDLE, B_ACT, B_RD, B_WR, B_PRE} bstate_e;

  bstate_e            st    [4];
  logic [ROW_W-1:0]   row_q [4];
  logic [PTW-1:0]     pt    [4];
  logic [BCW-1:0]     b_left;
  logic [1:0]         b_bank;
  logic               b_wr, b_ap;
  logic [MW-1:0]      mwait;
  logic               r0, r1, m0, m1;
  logic [1:0]         warm;

  logic [3:0] rdy, opn, bsel, pre_mask;
  wire  [2:0] op  = {ras_n, cas_n, we_n};
  wire        sel = !cs_n;

  wire is_act = sel && op == 3'b011;
  wire is_rd  = sel && op == 3'b101;
  wire is_wr  = sel && op == 3'b100;
  wire is_bst = sel && op == 3'b110;
  wire is_pre = sel && op == 3'b010;
  wire is_ref = sel && op == 3'b001;
  wire is_mrs = sel && op == 3'b000;
  wire any_cmd = sel && op != 3'b111;

  always_comb begin
    for (int b = 0; b < 4; b++) begin
      rdy[b] = st[b] == B_IDLE || (st[b] == B_PRE && pt[b] == '0);
      opn[b] = st[b] == B_ACT || st[b] == B_RD || st[b] == B_WR;
    end
  end

  assign bsel     = 4'b0001 << ba;
  assign pre_mask = addr[AP_BIT] ? 4'b1111 : bsel;

  wire running = b_left != '0;
  wire ap_busy = running && b_ap;
  wire gap     = mwait != '0;

  wire ok_act = is_act && rdy[ba] && !gap;
  wire ok_rw  = (is_rd || is_wr) && opn[ba] && !ap_busy && !gap;
  wire ok_bst = is_bst && !gap;
  wire ok_pre = is_pre && !gap && !(ap_busy && pre_mask[b_bank]);
  wire ok_ref = is_ref && (&rdy) && !gap;
  wire ok_mrs = is_mrs && (&rdy) && !gap;
  wire illegal = any_cmd && !(ok_act || ok_rw || ok_bst || ok_pre || ok_ref || ok_mrs);

  wire kill   = ok_bst || (ok_pre && pre_mask[b_bank]);
  wire beat   = ok_rw || (running && !kill);
  wire cur_wr = ok_rw ? is_wr : b_wr;

  assign rd_en     = beat && !cur_wr;
  assign wr_en     = beat && cur_wr && !dqm;
  assign beat_bank = ok_rw ? ba : b_bank;
  assign bank_open = opn;

  for (genvar g = 0; g < 4; g++) begin : g_row
    assign row_tbl[g*ROW_W +: ROW_W] = row_q[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < 4; b++) begin
        st[b]    <= B_IDLE;
        row_q[b] <= '0;
        pt[b]    <= '0;
      end
      b_left   <= '0;
      b_bank   <= '0;
      b_wr     <= 1'b0;
      b_ap     <= 1'b0;
      mwait    <= '0;
      cmd_seen <= '0;
      err      <= 1'b0;
      {r0, r1, m0, m1, dq_oe} <= '0;
      warm     <= '0;
    end else begin
      for (int b = 0; b < 4; b++) begin
        if (st[b] == B_PRE) begin
          if (pt[b] == '0) st[b] <= B_IDLE;
          else             pt[b] <= pt[b] - 1'b1;
        end
      end

      if (running) begin
        if (ok_rw || kill || b_left == BCW'(1)) begin
          b_left <= '0;
          if (b_ap) begin
            st[b_bank] <= B_PRE;
            pt[b_bank] <= PTW'(T_RP - 1);
          end else begin
            st[b_bank] <= B_ACT;
          end
        end else begin
          b_left <= b_left - 1'b1;
        end
      end

      if (ok_act) begin
        st[ba]    <= B_ACT;
        row_q[ba] <= addr;
      end

      if (ok_rw) begin
        b_bank <= ba;
        b_wr   <= is_wr;
        b_ap   <= addr[AP_BIT];
        if (BURST_LEN == 1) begin
          b_left <= '0;
          if (addr[AP_BIT]) begin
            st[ba] <= B_PRE;
            pt[ba] <= PTW'(T_RP - 1);
          end else begin
            st[ba] <= B_ACT;
          end
        end else begin
          b_left <= BCW'(BURST_LEN - 1);
          st[ba] <= is_wr ? B_WR : B_RD;
        end
      end

      if (ok_pre) begin
        for (int b = 0; b < 4; b++) begin
          if (pre_mask[b] && opn[b]) begin
            st[b] <= B_PRE;
            pt[b] <= PTW'(T_RP - 1);
          end
        end
      end

      if (ok_mrs)    mwait <= MW'(T_MRD - 1);
      else if (gap)  mwait <= mwait - 1'b1;

      cmd_seen <= {ok_mrs, ok_ref, ok_pre, ok_bst, ok_rw && is_wr, ok_rw && is_rd, ok_act};
      err      <= err || illegal;

      r0    <= rd_en;
      m0    <= dqm;
      r1    <= r0;
      m1    <= m0;
      dq_oe <= r1 && !m1;
      if (warm != 2'd3) warm <= warm + 1'b1;
    end
  end

  assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  assert_bad_no_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |=> (cmd_seen == '0));

  assert_bad_keeps_rows_R11: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |=> $stable(row_tbl));

  assert_mode_banks_closed_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_seen[6] |-> (bank_open == '0));

  assert_act_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_seen[0] |-> (bank_open != '0));

  assert_rd_mask_late_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd3 && $past(dqm, 3)) |-> !dq_oe);

endmodule

// File: tb/sdram_cmd_tracker_tb.sv
`timescale 1ns/100ps
module sdram_cmd_tracker_tb;

  localparam int ROW_W = 12;
  localparam int NV    = 31;

  localparam logic [2:0] NOP = 3'b111, ACT = 3'b011, RD = 3'b101, WR = 3'b100,
                         BST = 3'b110, PRE = 3'b010, REF = 3'b001, MRS = 3'b000;
  localparam logic [6:0] S0 = 7'd0, SA = 7'b0000001, SR = 7'b0000010, SW = 7'b0000100,
                         SB = 7'b0001000, SP = 7'b0010000, SF = 7'b0100000, SM = 7'b1000000;

  // {cs_n, op, ba, addr, dqm, exp rd_en, exp wr_en, exp cmd_seen, exp dq_oe, exp bank_open, exp err}
  localparam logic [33:0] VEC [NV] = '{
    {1'b0, MRS, 2'd0, 12'h000, 1'b0, 1'b0, 1'b0, SM, 1'b0, 4'b0000, 1'b0},
    {1'b0, NOP, 2'd0, 12'h000, 1'b0, 1'b0, 1'b0, S0, 1'b0, 4'b0000, 1'b0},
    {1'b0, REF, 2'd0, 12'h000, 1'b0, 1'b0, 1'b0, SF, 1'b0, 4'b0000, 1'b0},
    {1'b0, ACT, 2'd1, 12'h123, 1'b0, 1'b0, 1'b0, SA, 1'b0, 4'b0010, 1'b0},
    {1'b0, ACT, 2'd2, 12'h0AB, 1'b0, 1'b0, 1'b0, SA, 1'b0, 4'b0110, 1'b0},
    {1'b0, RD,  2'd1, 12'h000, 1'b0, 1'b1, 1'b0, SR, 1'b0, 4'b0110, 1'b0},
    {1'b0, NOP, 2'd0, 12'h000, 1'b1, 1'b1, 1'b0, S0, 1'b0, 4'b0110, 1'b0},
    {1'b0, NOP, 2'd0, 12'h000, 1'b0, 1'b1, 1'b0, S0, 1'b1, 4'b0110, 1'b0},
    {1'b0, WR,  2'd2, 12'h000, 1'b0, 1'b0, 1'b1, SW, 1'b0, 4'b0110, 1'b0},
    {1'b0, NOP, 2'd0, 12'h000, 1'b1, 1'b0, 1'b0, S0, 1'b1, 4'b0110, 1'b0},
    {1'b0, NOP, 2'd0, 12'h000, 1'b0, 1'b0, 1'b1, S0, 1'b0, 4'b0110, 1'b0},
    {1'b0, BST, 2'd0, 12'h000, 1'b0, 1'b0, 1'b0, SB, 1'b0, 4'b0110, 1'b0},
    {1'b0, NOP, 2'd0, 12'h000, 1'b0, 1'b0, 1'b0, S0, 1'b0, 4'b0110, 1'b0},
    {1'b0, RD,  2'd2, 12'h400, 1'b0, 1'b1, 1'b0, SR, 1'b0, 4'b0110, 1'b0},
    {1'b0, RD,  2'd1, 12'h000, 1'b0, 1'b1, 1'b0, S0, 1'b0, 4'b0110, 1'b1},
    {1'b0, NOP, 2'd0, 12'h000, 1'b0, 1'b1, 1'b0, S0, 1'b1, 4'b0110, 1'b1},
    {1'b0, NOP, 2'd0, 12'h000, 1'b0, 1'b1, 1'b0, S0, 1'b1, 4'b0010, 1'b1},
    {1'b0, ACT, 2'd2, 12'h055, 1'b0, 1'b0, 1'b0, S0, 1'b1, 4'b0010, 1'b1},
    {1'b0, ACT, 2'd2, 12'h055, 1'b0, 1'b0, 1'b0, SA, 1'b1, 4'b0110, 1'b1},
    {1'b0, PRE, 2'd0, 12'h400, 1'b0, 1'b0, 1'b0, SP, 1'b0, 4'b0000, 1'b1},
    {1'b0, REF, 2'd0, 12'h000, 1'b0, 1'b0, 1'b0, S0, 1'b0, 4'b0000, 1'b1},
    {1'b0, REF, 2'd0, 12'h000, 1'b0, 1'b0, 1'b0, SF, 1'b0, 4'b0000, 1'b1},
    {1'b0, RD,  2'd0, 12'h000, 1'b0, 1'b0, 1'b0, S0, 1'b0, 4'b0000, 1'b1},
    {1'b0, ACT, 2'd3, 12'hFFF, 1'b0, 1'b0, 1'b0, SA, 1'b0, 4'b1000, 1'b1},
    {1'b1, ACT, 2'd0, 12'h001, 1'b0, 1'b0, 1'b0, S0, 1'b0, 4'b1000, 1'b1},
    {1'b0, ACT, 2'd3, 12'h0AA, 1'b0, 1'b0, 1'b0, S0, 1'b0, 4'b1000, 1'b1},
    {1'b0, PRE, 2'd3, 12'h000, 1'b0, 1'b0, 1'b0, SP, 1'b0, 4'b0000, 1'b1},
    {1'b0, MRS, 2'd0, 12'h000, 1'b0, 1'b0, 1'b0, S0, 1'b0, 4'b0000, 1'b1},
    {1'b0, MRS, 2'd0, 12'h000, 1'b0, 1'b0, 1'b0, SM, 1'b0, 4'b0000, 1'b1},
    {1'b0, ACT, 2'd0, 12'h001, 1'b0, 1'b0, 1'b0, S0, 1'b0, 4'b0000, 1'b1},
    {1'b0, ACT, 2'd0, 12'h001, 1'b0, 1'b0, 1'b0, SA, 1'b0, 4'b0001, 1'b1}
  };

  string tags [NV] = '{"R10", "R10", "R10", "R2", "R2", "R3", "R5", "R5", "R13", "R4",
                       "R4", "R9", "R9", "R6", "R7", "R6", "R6", "R6", "R6", "R8",
                       "R10", "R10", "R11", "R2", "R1", "R11", "R8", "R10", "R10", "R10", "R2"};

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, dqm = 1'b0;
  logic [1:0] ba = '0;
  logic [ROW_W-1:0] addr = '0;
  logic rd_en, wr_en, dq_oe, err;
  logic [1:0] beat_bank;
  logic [6:0] cmd_seen;
  logic [3:0] bank_open;
  logic [4*ROW_W-1:0] row_tbl;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  sdram_cmd_tracker #(.ROW_W(ROW_W), .BURST_LEN(4), .T_RP(2), .T_MRD(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ba(ba), .addr(addr), .dqm(dqm), .rd_en(rd_en), .wr_en(wr_en), .beat_bank(beat_bank),
    .dq_oe(dq_oe), .cmd_seen(cmd_seen), .bank_open(bank_open), .row_tbl(row_tbl), .err(err));

  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input int step, input string what,
                     input logic [47:0] got, input logic [47:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s step %0d %s: actual %0h expected %0h", tag, step, what, got, exp);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R12", -1, "err", 48'(err), 48'd0);
    chk("R12", -1, "cmd_seen", 48'(cmd_seen), 48'd0);
    chk("R12", -1, "bank_open", 48'(bank_open), 48'd0);
    chk("R12", -1, "rd/wr/oe", 48'({rd_en, wr_en, dq_oe}), 48'd0);

    for (int i = 0; i < NV; i++) begin
      logic [33:0] v;
      v = VEC[i];
      cs_n = v[33];
      {ras_n, cas_n, we_n} = v[32:30];
      ba   = v[29:28];
      addr = v[27:16];
      dqm  = v[15];
      #1;
      chk(tags[i], i, "rd_en", 48'(rd_en), 48'(v[14]));
      chk(tags[i], i, "wr_en", 48'(wr_en), 48'(v[13]));
      if (i == 8) chk("R13", i, "beat_bank", 48'(beat_bank), 48'd2);
      @(negedge clk);
      chk(tags[i], i, "cmd_seen", 48'(cmd_seen), 48'(v[12:6]));
      chk(tags[i], i, "dq_oe", 48'(dq_oe), 48'(v[5]));
      chk(tags[i], i, "bank_open", 48'(bank_open), 48'(v[4:1]));
      chk(tags[i], i, "err", 48'(err), 48'(v[0]));
      if (i == 3)  chk("R2", i, "row bank1", 48'(row_tbl[1*ROW_W +: ROW_W]), 48'h123);
      if (i == 18) chk("R6", i, "row bank2", 48'(row_tbl[2*ROW_W +: ROW_W]), 48'h055);
      if (i == 25) chk("R11", i, "row bank3", 48'(row_tbl[3*ROW_W +: ROW_W]), 48'hFFF);
    end

    cs_n = 1'b1;
    {ras_n, cas_n, we_n} = NOP;
    rst_n = 1'b0;
    @(negedge clk);
    chk("R12", NV, "err after reset", 48'(err), 48'd0);
    chk("R12", NV, "bank_open after reset", 48'(bank_open), 48'd0);
    chk("R12", NV, "cmd_seen after reset", 48'(cmd_seen), 48'd0);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule